// File: doc/BRIEF.md
# T3 PLCP Frame Receiver

This block takes the octet-aligned payload of a T3 line that carries a PLCP frame and recovers the frame. It hunts for the two framing octets followed by a valid path-overhead identifier. It locks once two rows in a row agree, and it then follows the 12-row structure. While locked it delivers the 53-octet cell of every row on a strobed octet output with a start-of-cell marker.

While in frame, the path overhead octets are decoded. B1 is checked as a BIP-8 against the frame sent before. The far-end block error field of G1 is accumulated, the yellow-alarm bit is filtered over ten frames, and the link status bits are presented. C1 selects whether the trailer that ends the frame is 13 or 14 nibbles long. The upstream nibble aligner delivers each trailer nibble on its own enable, in the low half of the octet lane.

Top module: `t3_plcp_rx`

## Requirements
- R1: `in_frame` rises on the clock edge that samples the identifier octet of the second of two consecutive rows. Each of those rows must start with F6h then 28h, and their identifier octets must follow the expected order. The identifier codes for rows 0 to 11 are 2Ch, 29h, 25h, 20h, 1Ch, 19h, 15h, 10h, 0Dh, 08h, 04h, 01h. A candidate row carrying 01h (row 11) is discarded. Octets that never form this pattern leave `in_frame` low.
- R2: While in frame, a row whose framing or identifier octets are wrong is tolerated when it stands alone. On the second consecutive such row, `in_frame` falls on the edge that samples its identifier octet, and `lof_evt` pulses high for exactly that cycle.
- R3: While in frame, octets 5 to 57 of each row (the cell) appear on `cell_data`, with `cell_vld` high one cycle after their enable. `cell_sop` marks the first octet of each cell. No strobe is given for overhead or trailer enables, or out of frame.
- R4: The row-7 overhead octet (B1) is XORed with the even parity of every overhead and cell octet of the previous frame. The number of differing bits is added to `bip_cnt` on the edge that samples B1. This happens only when the previous frame was in frame from its first octet.
- R5: G1 is the row-8 overhead octet. In frame, its bits 7:4 are added to `febe_cnt` when they hold 0 to 8. Values 9 to 15 leave the count unchanged.
- R6: `yellow` sets after G1 bit 3 has been 1 in ten consecutive frames, and clears after it has been 0 in ten consecutive frames. A single differing frame restarts the run.
- R7: `link_stat` holds G1 bits 2:0 of the most recent in-frame G1.
- R8: C1 is the row-11 overhead octet. In frame, FFh or 66h selects a 13-nibble trailer (`trl_long`=0), and 00h or 99h selects 14 nibbles (`trl_long`=1). Any other value keeps the previous length. Frame tracking skips exactly that many trailer enables.
- R9: After reset, `in_frame`, `lof_evt`, `cell_vld`, `yellow` and `trl_long` are 0, and both counters are 0.
- R10: A cycle with `oct_en` low advances nothing: it raises no `cell_vld` or `lof_evt`, and it does not change the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oct_en | input | 1 | Octet (or trailer nibble) valid |
| oct | input | 8 | Received octet; trailer nibble in bits 3:0 |
| in_frame | output | 1 | PLCP frame lock |
| lof_evt | output | 1 | One-cycle pulse on loss of frame |
| cell_vld | output | 1 | Cell octet strobe |
| cell_sop | output | 1 | First octet of a cell |
| cell_data | output | 8 | Cell octet |
| bip_cnt | output | CNT_W | Saturating B1 bit-error count |
| febe_cnt | output | CNT_W | Saturating far-end block error count |
| yellow | output | 1 | Filtered yellow alarm |
| link_stat | output | 3 | Last G1 link status bits |
| trl_long | output | 1 | Current trailer is 14 nibbles |

## Verification
On every cycle the assertions check the following. Cell strobes occur only in frame. A start-of-cell marker never comes without a strobe. A loss pulse always marks a drop of lock. Both counters never decrease and never move on an idle cycle. The FEBE count grows by at most eight per step. The bench scenarios alone can show that lock needs two ordered rows and survives a single bad row. They also show that B1 is judged against the frame before, that it is skipped after a partial frame, that illegal FEBE values and illegal C1 codes are ignored, and that the ten-frame yellow filter restarts on an interruption.

// File: rtl/t3plcp_pkg.sv
package t3plcp_pkg;
  localparam int ROWS       = 12;
  localparam int ROW_OCTETS = 57;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int COL_W      = $clog2(ROW_OCTETS);
  localparam int POH_COL    = 3;
  localparam int CELL_COL   = 4;
  localparam logic [7:0] FRM_HI = 8'hF6;
  localparam logic [7:0] FRM_LO = 8'h28;
  localparam int B1_ROW     = 7;
  localparam int G1_ROW     = 8;
  localparam int C1_ROW     = 11;
  localparam int TRL_W      = 4;
  localparam int TRL_SHORT  = 13;
  localparam int FEBE_LIMIT = 8;

  typedef enum logic [2:0] {S_HUNT, S_HI, S_POI, S_CONF, S_SYNC, S_TRL} trk_state_t;

  function automatic logic [7:0] poi_code(input logic [ROW_W-1:0] idx);
    case (idx)
      4'd0:    poi_code = 8'h2C;
      4'd1:    poi_code = 8'h29;
      4'd2:    poi_code = 8'h25;
      4'd3:    poi_code = 8'h20;
      4'd4:    poi_code = 8'h1C;
      4'd5:    poi_code = 8'h19;
      4'd6:    poi_code = 8'h15;
      4'd7:    poi_code = 8'h10;
      4'd8:    poi_code = 8'h0D;
      4'd9:    poi_code = 8'h08;
      4'd10:   poi_code = 8'h04;
      default: poi_code = 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/plcp_row_tracker.sv
module plcp_row_tracker
  import t3plcp_pkg::*;
#(
  parameter int MISS_LIM = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [7:0]       d,
  input  logic [TRL_W-1:0] trl_len,
  output logic             in_frame,
  output logic             lof_evt,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             sync_now,
  output logic             frame_start,
  output logic             frame_end
);
  localparam int MISS_W = $clog2(MISS_LIM + 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_OCTETS - 1);

  trk_state_t        st;
  logic [MISS_W-1:0] miss;
  logic [TRL_W-1:0]  tcnt;
  logic              bad_q;
  logic              poi_hit, row_ok;
  logic [ROW_W-1:0]  poi_idx;

  always_comb begin
    poi_hit = 1'b0;
    poi_idx = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (d == poi_code(ROW_W'(i))) begin
        poi_hit = 1'b1;
        poi_idx = ROW_W'(i);
      end
    end
  end

  assign row_ok      = !bad_q && (d == poi_code(row));
  assign sync_now    = (st == S_SYNC);
  assign frame_end   = en && sync_now && (row == ROW_W'(ROWS - 1)) && (col == LAST_COL);
  assign frame_start = en && (st == S_TRL) && (tcnt == trl_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) bad_q <= 1'b0;
    else if (en && col == '0) bad_q <= (d != FRM_HI);
    else if (en && col == COL_W'(1)) bad_q <= bad_q | (d != FRM_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HUNT; col <= '0; row <= '0; miss <= '0; tcnt <= '0;
      in_frame <= 1'b0; lof_evt <= 1'b0;
    end else begin
      lof_evt <= 1'b0;
      if (en) begin
        case (st)
          S_HUNT: if (d == FRM_HI) st <= S_HI;
          S_HI: begin
            if (d == FRM_LO) st <= S_POI;
            else if (d != FRM_HI) st <= S_HUNT;
          end
          S_POI: begin
            if (poi_hit && poi_idx != ROW_W'(ROWS - 1)) begin
              st <= S_CONF; row <= poi_idx; col <= COL_W'(POH_COL);
            end else st <= S_HUNT;
          end
          S_CONF, S_SYNC: begin
            if (col == LAST_COL) begin
              col <= '0;
              if (row == ROW_W'(ROWS - 1)) begin st <= S_TRL; tcnt <= '0; end
              else row <= row + 1'b1;
            end else col <= col + 1'b1;
            if (col == COL_W'(2)) begin
              if (st == S_CONF) begin
                if (row_ok) begin st <= S_SYNC; in_frame <= 1'b1; miss <= '0; end
                else st <= S_HUNT;
              end else if (!row_ok) begin
                if (miss == MISS_W'(MISS_LIM - 1)) begin
                  st <= S_HUNT; in_frame <= 1'b0; lof_evt <= 1'b1; miss <= '0;
                end else miss <= miss + 1'b1;
              end else miss <= '0;
            end
          end
          S_TRL: begin
            if (tcnt == trl_len - 1'b1) begin st <= S_SYNC; col <= '0; row <= '0; end
            else tcnt <= tcnt + 1'b1;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/plcp_bip_check.sv
module plcp_bip_check
  import t3plcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             b1_stb,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             in_frame,
  input  logic [7:0]       d,
  output logic [CNT_W-1:0] bip_cnt
);
  logic [7:0]   acc, prev;
  logic         full, prev_vld;
  logic [3:0]   nbits;
  logic [CNT_W:0] sum;

  always_comb begin
    nbits = '0;
    for (int i = 0; i < 8; i++) nbits = nbits + {3'b0, prev[i] ^ d[i]};
    sum = {1'b0, bip_cnt} + {{(CNT_W-3){1'b0}}, nbits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; prev <= '0; full <= 1'b0; prev_vld <= 1'b0; bip_cnt <= '0;
    end else begin
      if (take) acc <= acc ^ d;
      if (frame_end) begin
        prev <= acc ^ d; prev_vld <= full; acc <= '0;
      end
      if (frame_start) begin acc <= '0; full <= 1'b1; end
      if (b1_stb && prev_vld) bip_cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      if (!in_frame) begin full <= 1'b0; prev_vld <= 1'b0; end
    end
  end
endmodule

// File: rtl/plcp_oh_monitor.sv
module plcp_oh_monitor
  import t3plcp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int YEL_FRAMES = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             poh_stb,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       d,
  output logic [CNT_W-1:0] febe_cnt,
  output logic             yellow,
  output logic [2:0]       link_stat,
  output logic             trl_long
);
  localparam int RUN_W = $clog2(YEL_FRAMES + 1);

  logic [RUN_W-1:0] run;
  logic [CNT_W:0]   sum;
  logic             g1_stb, c1_stb;

  assign g1_stb = poh_stb && (row == ROW_W'(G1_ROW));
  assign c1_stb = poh_stb && (row == ROW_W'(C1_ROW));
  assign sum    = {1'b0, febe_cnt} + {{(CNT_W-3){1'b0}}, d[7:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      febe_cnt <= '0; yellow <= 1'b0; link_stat <= '0; trl_long <= 1'b0; run <= '0;
    end else begin
      if (g1_stb) begin
        if (d[7:4] <= 4'(FEBE_LIMIT)) febe_cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        link_stat <= d[2:0];
        if (d[3] == yellow) run <= '0;
        else if (run == RUN_W'(YEL_FRAMES - 1)) begin yellow <= ~yellow; run <= '0; end
        else run <= run + 1'b1;
      end
      if (c1_stb) begin
        case (d)
          8'hFF, 8'h66: trl_long <= 1'b0;
          8'h00, 8'h99: trl_long <= 1'b1;
          default:      trl_long <= trl_long;
        endcase
      end
    end
  end
endmodule

// File: rtl/t3_plcp_rx.sv
module t3_plcp_rx
  import t3plcp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int YEL_FRAMES = 10,
  parameter int MISS_LIM   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oct_en,
  input  logic [7:0]       oct,
  output logic             in_frame,
  output logic             lof_evt,
  output logic             cell_vld,
  output logic             cell_sop,
  output logic [7:0]       cell_data,
  output logic [CNT_W-1:0] bip_cnt,
  output logic [CNT_W-1:0] febe_cnt,
  output logic             yellow,
  output logic [2:0]       link_stat,
  output logic             trl_long
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             sync_now, frame_start, frame_end;
  logic             poh_stb, cell_stb, take;
  logic [TRL_W-1:0] trl_len;

  assign trl_len  = TRL_W'(TRL_SHORT) + {{(TRL_W-1){1'b0}}, trl_long};
  assign poh_stb  = oct_en && sync_now && (col == COL_W'(POH_COL));
  assign cell_stb = oct_en && sync_now && (col >= COL_W'(CELL_COL));
  assign take     = poh_stb || cell_stb;

  plcp_row_tracker #(.MISS_LIM(MISS_LIM)) u_trk (
    .clk(clk), .rst(rst), .en(oct_en), .d(oct), .trl_len(trl_len),
    .in_frame(in_frame), .lof_evt(lof_evt), .row(row), .col(col),
    .sync_now(sync_now), .frame_start(frame_start), .frame_end(frame_end)
  );

  plcp_bip_check #(.CNT_W(CNT_W)) u_bip (
    .clk(clk), .rst(rst), .take(take),
    .b1_stb(poh_stb && row == ROW_W'(B1_ROW)),
    .frame_start(frame_start), .frame_end(frame_end), .in_frame(in_frame),
    .d(oct), .bip_cnt(bip_cnt)
  );

  plcp_oh_monitor #(.CNT_W(CNT_W), .YEL_FRAMES(YEL_FRAMES)) u_oh (
    .clk(clk), .rst(rst), .poh_stb(poh_stb), .row(row), .d(oct),
    .febe_cnt(febe_cnt), .yellow(yellow), .link_stat(link_stat), .trl_long(trl_long)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_vld <= 1'b0; cell_sop <= 1'b0; cell_data <= '0;
    end else begin
      cell_vld <= cell_stb;
      cell_sop <= cell_stb && (col == COL_W'(CELL_COL));
      if (cell_stb) cell_data <= oct;
    end
  end
endmodule

// File: rtl/t3_plcp_rx_chk.sv
module t3_plcp_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             oct_en,
  input logic             in_frame,
  input logic             lof_evt,
  input logic             cell_vld,
  input logic             cell_sop,
  input logic [CNT_W-1:0] bip_cnt,
  input logic [CNT_W-1:0] febe_cnt
);
  p_sop_has_vld_r3: assert property (@(posedge clk) disable iff (rst)
    cell_sop |-> cell_vld);
  p_cell_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    cell_vld |-> in_frame);
  p_lof_drops_lock_r2: assert property (@(posedge clk) disable iff (rst)
    lof_evt |-> (!in_frame && $past(in_frame)));
  p_bip_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    oct_en |=> (bip_cnt >= $past(bip_cnt)));
  p_febe_step_r5: assert property (@(posedge clk) disable iff (rst)
    oct_en |=> ((febe_cnt - $past(febe_cnt)) <= CNT_W'(8)));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !oct_en |=> (!cell_vld && !lof_evt && $stable(bip_cnt) && $stable(febe_cnt)));
endmodule

bind t3_plcp_rx t3_plcp_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .oct_en(oct_en), .in_frame(in_frame), .lof_evt(lof_evt),
  .cell_vld(cell_vld), .cell_sop(cell_sop), .bip_cnt(bip_cnt), .febe_cnt(febe_cnt)
);

// File: tb/t3_plcp_rx_bench.sv
`timescale 1ns/1ps
module t3_plcp_rx_bench;
  logic        clk = 1'b0, rst = 1'b1, oct_en = 1'b0;
  logic [7:0]  oct = '0;
  logic        in_frame, lof_evt, cell_vld, cell_sop, yellow, trl_long;
  logic [7:0]  cell_data;
  logic [15:0] bip_cnt, febe_cnt;
  logic [2:0]  link_stat;

  t3_plcp_rx u_t3_plcp_rx (
    .clk(clk), .rst(rst), .oct_en(oct_en), .oct(oct), .in_frame(in_frame),
    .lof_evt(lof_evt), .cell_vld(cell_vld), .cell_sop(cell_sop), .cell_data(cell_data),
    .bip_cnt(bip_cnt), .febe_cnt(febe_cnt), .yellow(yellow), .link_stat(link_stat),
    .trl_long(trl_long)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, nput = 0;
  bit done = 0;
  // reference model state
  bit e_lock = 0, e_yel = 0, e_long = 0, cand = 0, frame_full = 0, prev_ok = 0;
  int miss = 0, yel_run = 0, e_bip = 0, e_febe = 0;
  logic [2:0] e_link = '0;
  logic [7:0] acc = '0, prev_bip = '0;

  function automatic logic [7:0] code_of(int r);
    logic [7:0] t[12] = '{8'h2C, 8'h29, 8'h25, 8'h20, 8'h1C, 8'h19,
                          8'h15, 8'h10, 8'h0D, 8'h08, 8'h04, 8'h01};
    return t[r];
  endfunction

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(bit vld, bit sop, logic [7:0] b, bit lof);
    vectors++;
    cmp("R1 in_frame", int'(in_frame), int'(e_lock));
    cmp("R2 lof_evt", int'(lof_evt), int'(lof));
    cmp("R3 cell_vld", int'(cell_vld), int'(vld));
    cmp("R3 cell_sop", int'(cell_sop), int'(sop));
    if (vld) cmp("R3 cell_data", int'(cell_data), int'(b));
    cmp("R4 bip_cnt", int'(bip_cnt), e_bip);
    cmp("R5 febe_cnt", int'(febe_cnt), e_febe);
    cmp("R6 yellow", int'(yellow), int'(e_yel));
    cmp("R7 link_stat", int'(link_stat), int'(e_link));
    cmp("R8 trl_long", int'(trl_long), int'(e_long));
  endtask

  // drive one enable at a negedge, compare at the following negedge
  task automatic put(logic [7:0] b, bit vld, bit sop, bit lof);
    oct = b; oct_en = 1'b1;
    @(negedge clk);
    check_all(vld, sop, b, lof);
    nput++;
    if (nput % 11 == 0) begin  // R10: idle cycle changes nothing
      oct_en = 1'b0; oct = 8'hF6;
      @(negedge clk);
      check_all(1'b0, 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic send_frame(logic [7:0] g1, logic [7:0] c1, int ntrl,
                            logic [7:0] b1_mask, logic [11:0] bad_rows);
    for (int r = 0; r < 12; r++) begin
      bit bad = bad_rows[r];
      bit lofx = 0;
      logic [7:0] poh;
      put(bad ? 8'h00 : 8'hF6, 0, 0, 0);
      put(8'h28, 0, 0, 0);
      if (e_lock) begin
        if (bad) begin
          miss++;
          if (miss == 2) begin
            e_lock = 0; lofx = 1; cand = 0; miss = 0; frame_full = 0; prev_ok = 0;
          end
        end else miss = 0;
      end else begin
        if (bad) cand = 0;
        else if (cand) begin e_lock = 1; miss = 0; cand = 0; end
        else cand = (r != 11);
      end
      put(code_of(r), 0, 0, lofx);
      poh = 8'h00;
      if (r == 7) begin
        poh = prev_bip ^ b1_mask;
        if (e_lock && prev_ok) e_bip += $countones(b1_mask);
      end else if (r == 8) begin
        poh = g1;
        if (e_lock) begin
          if (g1[7:4] <= 8) e_febe += int'(g1[7:4]);
          e_link = g1[2:0];
          if (g1[3] == e_yel) yel_run = 0;
          else begin
            yel_run++;
            if (yel_run == 10) begin e_yel = !e_yel; yel_run = 0; end
          end
        end
      end else if (r == 11) begin
        poh = c1;
        if (e_lock) begin
          if (c1 == 8'hFF || c1 == 8'h66) e_long = 0;
          else if (c1 == 8'h00 || c1 == 8'h99) e_long = 1;
        end
      end
      acc ^= poh;
      put(poh, 0, 0, 0);
      for (int c = 0; c < 53; c++) begin
        logic [7:0] x = 8'($urandom) & 8'h7F;
        acc ^= x;
        if (r == 11 && c == 52) begin
          prev_bip = acc; prev_ok = frame_full && e_lock; acc = '0;
        end
        put(x, e_lock, e_lock && c == 0, 0);
      end
    end
    for (int n = 0; n < ntrl; n++) begin
      if (n == ntrl - 1) begin frame_full = e_lock; acc = '0; end
      put(8'($urandom) & 8'h0F, 0, 0, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_all(0, 0, 0, 0);          // R9 reset state
    rst = 1'b0;
    @(negedge clk);
    check_all(0, 0, 0, 0);          // R9 after release
    for (int i = 0; i < 40; i++) put(8'($urandom) & 8'h7F, 0, 0, 0);  // R1 no lock on noise
    send_frame(8'h00, 8'hFF, 13, 8'h00, 12'h000);   // R1 lock in row 1
    send_frame(8'h30, 8'h00, 14, 8'h00, 12'h000);   // R8 long trailer, R5 febe 3
    send_frame(8'h80, 8'h66, 13, 8'h81, 12'h000);   // R4 two bit errors, R5 febe 8
    send_frame(8'hC5, 8'hFF, 13, 8'h00, 12'h010);   // R5 illegal febe, R7, R2 single bad row
    send_frame(8'h00, 8'h00, 14, 8'h0F, 12'h000);   // R4 four bit errors
    send_frame(8'h02, 8'h99, 14, 8'h00, 12'h000);   // R8 phase-3 long
    send_frame(8'h00, 8'h5A, 14, 8'h00, 12'h000);   // R8 illegal code keeps 14
    send_frame(8'h00, 8'hFF, 13, 8'h00, 12'h003);   // R2 loss, then relock
    send_frame(8'h00, 8'h00, 14, 8'h10, 12'h000);   // R4 skipped after partial frame
    send_frame(8'h00, 8'h66, 13, 8'h01, 12'h000);   // R4 checked again
    for (int f = 0; f < 9; f++) send_frame(8'h08, (f % 3 == 1) ? 8'h00 : 8'hFF, (f % 3 == 1) ? 14 : 13, 0, 0);
    send_frame(8'h00, 8'hFF, 13, 0, 0);             // R6 run broken
    for (int f = 0; f < 10; f++) send_frame(8'h08, (f % 3 == 1) ? 8'h00 : 8'hFF, (f % 3 == 1) ? 14 : 13, 0, 0);
    for (int f = 0; f < 10; f++) send_frame(8'h00, (f % 3 == 1) ? 8'h00 : 8'hFF, (f % 3 == 1) ? 14 : 13, 0, 0);
    oct_en = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule